// File: doc/BRIEF.md
# Posted-Write Clock-Domain Bridge

This block carries register writes from a fast processor bus into a slow timer clock domain of about 32 kHz without stalling the bus. Each of five target registers (control, count low word, count high word, alarm low word, alarm high word) owns a one-deep posting slot. An accepted write is captured on the bus side, announced to the slow domain by a toggle request that passes through a two-flop synchronizer, and applied there, after which a toggle acknowledge returns through another two-flop synchronizer. Each slot exposes a pending flag in a read-only status word. A write to a slot whose flag is still set is dropped and reported with a one-cycle reject pulse.

Clears of the sticky interrupt flags travel differently. They never get rejected. A clear request launches a transaction carrying its bit mask. Any further clear bits that arrive while that transaction is in flight collect in a second accumulator, and they go out as the next transaction as soon as the acknowledge returns. The mask already in flight never changes. The sticky flags live in the slow domain. A slow-side event input sets them, and an applied clear drops them. The counter, the alarm comparator and the address decode are outside the block. The slow side shows only the applied register values, the update strobes and the flags.

Bus-side slot states are SLOT_IDLE and SLOT_WAIT. SLOT_IDLE goes to SLOT_WAIT on an accepted write. SLOT_WAIT goes back to SLOT_IDLE when the synchronized acknowledge equals the request toggle. The clear channel has the states CLR_IDLE and CLR_BUSY. CLR_IDLE goes to CLR_BUSY on a clear with a nonzero mask. CLR_BUSY stays in CLR_BUSY and relaunches when the acknowledge arrives with accumulated bits. CLR_BUSY returns to CLR_IDLE when the acknowledge arrives and nothing has accumulated.

Top module: `posted_write_bridge`

## Requirements
- R1: After reset, pend_status, wr_reject, irq_flags, slow_upd and slow_regs are all zero.
- R2: pend_status places the pending flags at fixed positions: alarm high word at bit 12, alarm low word at bit 11, count high word at bit 10, count low word at bit 9, clear channel at bit 8 and control at bit 7. Every other bit reads 0.
- R3: wr_sel selects the target: 0 control, 1 count low, 2 count high, 3 alarm low, 4 alarm high. A write (wr_en high) to an idle target sets its pending bit in the cycle after the sampling edge. The write is applied exactly once in the slow domain: one slow_upd[wr_sel] strobe, and slow_regs[wr_sel*DW +: DW] takes the written data. The pending bit clears only after the acknowledge has returned.
- R4: A write to a target whose pending bit is set is dropped. wr_reject is high for exactly the one cycle after the sampling edge, and the value later applied for that target is the first, accepted data.
- R5: The slots are independent. A write to an idle target is accepted while another target is pending.
- R6: A write with wr_sel of 5, 6 or 7 has no effect: no pending bit, no reject and no slow update.
- R7: A clear request (clr_en high) with a nonzero clr_mask is always accepted and sets pend_status bit 8 in the next cycle. A clear with an all-zero mask launches nothing and leaves the flags unchanged.
- R8: Clear bits posted while a clear is in flight are merged into one following transaction. Bit 8 stays high until both transactions are done, no posted bit is lost, and a mask is presented to the slow domain only as a whole, once per transaction.
- R9: irq_flags are sticky. An evt_set bit sets its flag at the next slow edge and wins over a clear in the same cycle. A flag falls only on a slow edge where slow_clr_valid is high with that bit set in slow_clr_mask. A zero bit in a clear mask leaves its flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Fast bus clock |
| rst_bus_n | input | 1 | Active-low reset, bus domain |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Target register select |
| wr_data | input | DW | Write data |
| clr_en | input | 1 | Interrupt clear strobe |
| clr_mask | input | CW | Write-1-to-clear mask |
| wr_reject | output | 1 | One-cycle pulse for a dropped write |
| pend_status | output | 16 | Pending flags word |
| clk_slow | input | 1 | Slow timer clock |
| rst_slow_n | input | 1 | Active-low reset, slow domain |
| evt_set | input | CW | Interrupt event set inputs |
| slow_upd | output | NREG | Per-register apply strobes |
| slow_regs | output | NREG*DW | Applied register values, register i at bits i*DW |
| irq_flags | output | CW | Sticky interrupt flags |
| slow_clr_valid | output | 1 | Strobe for an applied clear |
| slow_clr_mask | output | CW | Mask of the applied clear |

## Verification
The assertions assume that wr_en, wr_sel and clr_en are synchronous to clk_bus, that evt_set is synchronous to clk_slow, and that each reset is held low over several edges of its own clock. The bench drives bus inputs only on clk_bus falling edges and slow inputs only on clk_slow falling edges. It releases the slow reset before the bus reset, and it uses a slow clock period that does not divide the bus period, roughly 200 times longer. Every clear merge is posted within a few bus cycles of the launch, well inside the handshake time, so that the merge path is actually taken.

// File: rtl/pwb_pkg.sv
`timescale 1ns/1ps
package pwb_pkg;
    localparam int NREG   = 5;
    localparam int SEL_W  = 3;
    localparam int STAT_W = 16;

    localparam int PB_CTRL = 7;
    localparam int PB_CLR  = 8;

    typedef enum logic {
        SLOT_IDLE,
        SLOT_WAIT
    } slot_st_e;

    typedef enum logic {
        CLR_IDLE,
        CLR_BUSY
    } clr_st_e;

    // status bit of slot idx: control at 7, the four data words at 9..12
    function automatic int pend_pos(input int idx);
        return (idx == 0) ? PB_CTRL : (PB_CLR + idx);
    endfunction
endpackage

// File: rtl/pwb_sync.sv
`timescale 1ns/1ps
module pwb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pwb_post_slot.sv
`timescale 1ns/1ps
module pwb_post_slot
    import pwb_pkg::*;
#(
    parameter int DW     = 16,
    parameter int STAGES = 2
) (
    input  logic          clk_bus,
    input  logic          rst_bus_n,
    input  logic          wr_hit,
    input  logic [DW-1:0] wr_data,
    output logic          pending,
    output logic          reject,
    input  logic          clk_slow,
    input  logic          rst_slow_n,
    output logic          slow_upd,
    output logic [DW-1:0] slow_val
);
    slot_st_e      st, st_nx;
    logic          req_tgl, ack_s, req_s, ack_tgl;
    logic [DW-1:0] hold;

    // state register
    always_ff @(posedge clk_bus or negedge rst_bus_n) begin
        if (!rst_bus_n) st <= SLOT_IDLE;
        else            st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            SLOT_IDLE: if (wr_hit)            st_nx = SLOT_WAIT;
            SLOT_WAIT: if (ack_s == req_tgl)  st_nx = SLOT_IDLE;
        endcase
    end

    // capture, request toggle and reject pulse
    always_ff @(posedge clk_bus or negedge rst_bus_n) begin
        if (!rst_bus_n) begin
            hold    <= '0;
            req_tgl <= 1'b0;
            reject  <= 1'b0;
        end else begin
            reject <= (st == SLOT_WAIT) && wr_hit;
            if (st == SLOT_IDLE && wr_hit) begin
                hold    <= wr_data;
                req_tgl <= ~req_tgl;
            end
        end
    end

    // outputs
    always_comb pending = (st == SLOT_WAIT);

    pwb_sync #(.STAGES(STAGES)) u_req_sync (
        .clk(clk_slow), .rst_n(rst_slow_n), .d(req_tgl), .q(req_s));

    // slow side: apply once per toggle, then echo it back
    always_ff @(posedge clk_slow or negedge rst_slow_n) begin
        if (!rst_slow_n) begin
            ack_tgl  <= 1'b0;
            slow_upd <= 1'b0;
            slow_val <= '0;
        end else begin
            slow_upd <= 1'b0;
            if (req_s != ack_tgl) begin
                ack_tgl  <= req_s;
                slow_val <= hold;
                slow_upd <= 1'b1;
            end
        end
    end

    pwb_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk(clk_bus), .rst_n(rst_bus_n), .d(ack_tgl), .q(ack_s));
endmodule

// File: rtl/pwb_clr_chan.sv
`timescale 1ns/1ps
module pwb_clr_chan
    import pwb_pkg::*;
#(
    parameter int CW     = 4,
    parameter int STAGES = 2
) (
    input  logic          clk_bus,
    input  logic          rst_bus_n,
    input  logic          clr_en,
    input  logic [CW-1:0] clr_mask,
    output logic          pending,
    input  logic          clk_slow,
    input  logic          rst_slow_n,
    input  logic [CW-1:0] evt_set,
    output logic [CW-1:0] flags,
    output logic          slow_clr_valid,
    output logic [CW-1:0] slow_clr_mask
);
    clr_st_e       st, st_nx;
    logic [CW-1:0] launched, acc, new_bits, merged;
    logic          req_tgl, ack_s, req_s, ack_tgl, done;

    assign new_bits = clr_en ? clr_mask : '0;
    assign merged   = acc | new_bits;
    assign done     = (st == CLR_BUSY) && (ack_s == req_tgl);

    // state register
    always_ff @(posedge clk_bus or negedge rst_bus_n) begin
        if (!rst_bus_n) st <= CLR_IDLE;
        else            st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            CLR_IDLE: if (|new_bits)         st_nx = CLR_BUSY;
            CLR_BUSY: if (done && !(|merged)) st_nx = CLR_IDLE;
        endcase
    end

    // launched mask is frozen while in flight; late bits go to acc
    always_ff @(posedge clk_bus or negedge rst_bus_n) begin
        if (!rst_bus_n) begin
            launched <= '0;
            acc      <= '0;
            req_tgl  <= 1'b0;
        end else begin
            unique case (st)
                CLR_IDLE: begin
                    if (|new_bits) begin
                        launched <= new_bits;
                        req_tgl  <= ~req_tgl;
                    end
                end
                CLR_BUSY: begin
                    if (done) begin
                        acc <= '0;
                        if (|merged) begin
                            launched <= merged;
                            req_tgl  <= ~req_tgl;
                        end
                    end else begin
                        acc <= merged;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb pending = (st == CLR_BUSY);

    pwb_sync #(.STAGES(STAGES)) u_req_sync (
        .clk(clk_slow), .rst_n(rst_slow_n), .d(req_tgl), .q(req_s));

    // slow side sticky flags; a same-cycle event wins over the clear
    always_ff @(posedge clk_slow or negedge rst_slow_n) begin
        if (!rst_slow_n) begin
            ack_tgl        <= 1'b0;
            flags          <= '0;
            slow_clr_valid <= 1'b0;
            slow_clr_mask  <= '0;
        end else begin
            slow_clr_valid <= 1'b0;
            if (req_s != ack_tgl) begin
                ack_tgl        <= req_s;
                slow_clr_valid <= 1'b1;
                slow_clr_mask  <= launched;
                flags          <= (flags & ~launched) | evt_set;
            end else begin
                flags <= flags | evt_set;
            end
        end
    end

    pwb_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk(clk_bus), .rst_n(rst_bus_n), .d(ack_tgl), .q(ack_s));
endmodule

// File: rtl/posted_write_bridge.sv
`timescale 1ns/1ps
module posted_write_bridge
    import pwb_pkg::*;
#(
    parameter int DW          = 16,
    parameter int CW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_bus,
    input  logic               rst_bus_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [DW-1:0]      wr_data,
    input  logic               clr_en,
    input  logic [CW-1:0]      clr_mask,
    output logic               wr_reject,
    output logic [STAT_W-1:0]  pend_status,
    input  logic               clk_slow,
    input  logic               rst_slow_n,
    input  logic [CW-1:0]      evt_set,
    output logic [NREG-1:0]    slow_upd,
    output logic [NREG*DW-1:0] slow_regs,
    output logic [CW-1:0]      irq_flags,
    output logic               slow_clr_valid,
    output logic [CW-1:0]      slow_clr_mask
);
    logic [NREG-1:0] pend_vec, rej_vec;
    logic            clr_pend;

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_sel == SEL_W'(g));

        pwb_post_slot #(.DW(DW), .STAGES(SYNC_STAGES)) u_slot (
            .clk_bus    (clk_bus),
            .rst_bus_n  (rst_bus_n),
            .wr_hit     (hit),
            .wr_data    (wr_data),
            .pending    (pend_vec[g]),
            .reject     (rej_vec[g]),
            .clk_slow   (clk_slow),
            .rst_slow_n (rst_slow_n),
            .slow_upd   (slow_upd[g]),
            .slow_val   (slow_regs[g*DW +: DW])
        );
    end

    pwb_clr_chan #(.CW(CW), .STAGES(SYNC_STAGES)) u_clr (
        .clk_bus        (clk_bus),
        .rst_bus_n      (rst_bus_n),
        .clr_en         (clr_en),
        .clr_mask       (clr_mask),
        .pending        (clr_pend),
        .clk_slow       (clk_slow),
        .rst_slow_n     (rst_slow_n),
        .evt_set        (evt_set),
        .flags          (irq_flags),
        .slow_clr_valid (slow_clr_valid),
        .slow_clr_mask  (slow_clr_mask)
    );

    assign wr_reject = |rej_vec;

    always_comb begin
        pend_status = '0;
        for (int i = 0; i < NREG; i++) pend_status[pend_pos(i)] = pend_vec[i];
        pend_status[PB_CLR] = clr_pend;
    end
endmodule

// File: rtl/pwb_chk.sv
`timescale 1ns/1ps
module pwb_chk
    import pwb_pkg::*;
#(
    parameter int CW = 4
) (
    input logic             clk_bus,
    input logic             rst_bus_n,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_sel,
    input logic             clr_en,
    input logic [CW-1:0]    clr_mask,
    input logic             wr_reject,
    input logic [5:0]       pend6,
    input logic             clk_slow,
    input logic             rst_slow_n,
    input logic [CW-1:0]    evt_set,
    input logic [CW-1:0]    irq_flags,
    input logic             slow_clr_valid,
    input logic [CW-1:0]    slow_clr_mask
);
    logic hit_pend;
    always_comb begin
        hit_pend = 1'b0;
        for (int i = 0; i < NREG; i++)
            if (wr_sel == SEL_W'(i)) hit_pend = pend6[pend_pos(i) - PB_CTRL];
    end

    // R4
    reject_cause_chk: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        wr_reject |-> $past(wr_en && hit_pend));

    for (genvar g = 0; g < NREG; g++) begin : g_rise
        // R3
        pend_rise_chk: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
            $rose(pend6[pend_pos(g) - PB_CTRL]) |-> $past(wr_en && wr_sel == SEL_W'(g)));
    end

    // R7
    clr_rise_chk: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        $rose(pend6[PB_CLR - PB_CTRL]) |-> $past(clr_en && (|clr_mask)));

    for (genvar b = 0; b < CW; b++) begin : g_flag
        // R9
        flag_fall_chk: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
            $fell(irq_flags[b]) |-> (slow_clr_valid && slow_clr_mask[b]));
        // R9
        flag_set_chk: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
            evt_set[b] |=> irq_flags[b]);
    end
endmodule

bind posted_write_bridge pwb_chk #(.CW(CW)) u_pwb_chk (
    .clk_bus        (clk_bus),
    .rst_bus_n      (rst_bus_n),
    .wr_en          (wr_en),
    .wr_sel         (wr_sel),
    .clr_en         (clr_en),
    .clr_mask       (clr_mask),
    .wr_reject      (wr_reject),
    .pend6          (pend_status[12:7]),
    .clk_slow       (clk_slow),
    .rst_slow_n     (rst_slow_n),
    .evt_set        (evt_set),
    .irq_flags      (irq_flags),
    .slow_clr_valid (slow_clr_valid),
    .slow_clr_mask  (slow_clr_mask)
);

// File: tb/tb_posted_write_bridge.sv
`timescale 1ns/1ps
module tb_posted_write_bridge;
    localparam int DW = 16;
    localparam int CW = 4;
    localparam int NR = 5;

    logic           clk_bus = 1'b0, clk_slow = 1'b0;
    logic           rst_bus_n = 1'b0, rst_slow_n = 1'b0;
    logic           wr_en = 1'b0, clr_en = 1'b0;
    logic [2:0]     wr_sel = '0;
    logic [DW-1:0]  wr_data = '0;
    logic [CW-1:0]  clr_mask = '0, evt_set = '0;
    logic           wr_reject, slow_clr_valid;
    logic [15:0]    pend_status;
    logic [NR-1:0]  slow_upd;
    logic [NR*DW-1:0] slow_regs;
    logic [CW-1:0]  irq_flags, slow_clr_mask;

    always #2.5   clk_bus  = ~clk_bus;
    always #498.7 clk_slow = ~clk_slow;

    posted_write_bridge #(.DW(DW), .CW(CW)) dut (.*);

    int tests = 0, failed = 0;
    int upd_cnt [NR];
    int exp_cnt [NR];
    logic [DW-1:0] exp_val [NR];
    int clr_cnt = 0;
    logic [CW-1:0] clr_union = '0;

    // slow-side monitor
    always @(negedge clk_slow) begin
        for (int r = 0; r < NR; r++) if (slow_upd[r]) upd_cnt[r]++;
        if (slow_clr_valid) begin
            clr_cnt++;
            clr_union |= slow_clr_mask;
        end
    end

    // {sel, data}
    localparam logic [18:0] VEC [8] = '{
        {3'd0, 16'h00A5}, {3'd1, 16'hFFFF}, {3'd2, 16'h0001}, {3'd3, 16'h8000},
        {3'd4, 16'h5A5A}, {3'd0, 16'h0F0F}, {3'd3, 16'h1357}, {3'd1, 16'h0000}
    };

    function automatic int bitpos(input int sel);
        case (sel)
            0: return 7;
            1: return 9;
            2: return 10;
            3: return 11;
            default: return 12;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] sel, input logic [DW-1:0] d);
        @(negedge clk_bus);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk_bus);
        wr_en = 1'b0;
    endtask

    task automatic bus_clear(input logic [CW-1:0] m);
        @(negedge clk_bus);
        clr_en = 1'b1; clr_mask = m;
        @(negedge clk_bus);
        clr_en = 1'b0; clr_mask = '0;
    endtask

    task automatic pulse_evt(input logic [CW-1:0] m);
        @(negedge clk_slow);
        evt_set = m;
        @(negedge clk_slow);
        evt_set = '0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (pend_status != 16'h0 && n < 5000) begin
            @(negedge clk_bus);
            n++;
        end
        chk(pend_status == 16'h0, tag, pend_status, 0);
        repeat (2) @(negedge clk_slow);
        @(negedge clk_bus);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk_bus);
        tests++; failed++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int r = 0; r < NR; r++) begin
            upd_cnt[r] = 0; exp_cnt[r] = 0; exp_val[r] = '0;
        end
        repeat (3) @(negedge clk_slow);
        rst_slow_n = 1'b1;
        @(negedge clk_bus);
        rst_bus_n = 1'b1;
        repeat (2) @(negedge clk_bus);

        // R1 reset state
        chk(pend_status == 16'h0, "R1 pend_status", pend_status, 0);
        chk(wr_reject == 1'b0,    "R1 wr_reject", wr_reject, 0);
        chk(irq_flags == '0,      "R1 irq_flags", irq_flags, 0);
        chk(slow_regs == '0 && slow_upd == '0, "R1 slow side", slow_regs[31:0], 0);

        // R3 / R2 vector table
        for (int v = 0; v < 8; v++) begin
            int s;
            s = int'(VEC[v][18:16]);
            bus_write(VEC[v][18:16], VEC[v][15:0]);
            chk(pend_status == (16'h1 << bitpos(s)), "R2 R3 pending bit", pend_status, 16'h1 << bitpos(s));
            chk(wr_reject == 1'b0, "R3 no reject when idle", wr_reject, 0);
            exp_cnt[s]++;
            exp_val[s] = VEC[v][15:0];
            wait_idle("R3 pending clears");
            chk(slow_regs[s*DW +: DW] == exp_val[s], "R3 applied data", slow_regs[s*DW +: DW], exp_val[s]);
            chk(upd_cnt[s] == exp_cnt[s], "R3 single update", upd_cnt[s], exp_cnt[s]);
        end

        // R4 reject while pending, R5 independent slot
        bus_write(3'd1, 16'hAAAA);
        exp_cnt[1]++; exp_val[1] = 16'hAAAA;
        bus_write(3'd1, 16'h5555);
        chk(wr_reject == 1'b1, "R4 reject pulse", wr_reject, 1);
        @(negedge clk_bus);
        chk(wr_reject == 1'b0, "R4 reject one cycle", wr_reject, 0);
        bus_write(3'd2, 16'h7777);
        exp_cnt[2]++; exp_val[2] = 16'h7777;
        chk(wr_reject == 1'b0, "R5 other slot accepted", wr_reject, 0);
        chk(pend_status == 16'h0600, "R5 two pending", pend_status, 16'h0600);
        chk((pend_status & 16'hE07F) == 16'h0, "R2 reserved zero", pend_status, 0);
        wait_idle("R4 idle");
        chk(slow_regs[1*DW +: DW] == 16'hAAAA, "R4 first data kept", slow_regs[1*DW +: DW], 16'hAAAA);
        chk(upd_cnt[1] == exp_cnt[1], "R4 dropped write not applied", upd_cnt[1], exp_cnt[1]);
        chk(slow_regs[2*DW +: DW] == 16'h7777, "R5 data", slow_regs[2*DW +: DW], 16'h7777);

        // R6 invalid select
        bus_write(3'd5, 16'hBEEF);
        chk(pend_status == 16'h0 && wr_reject == 1'b0, "R6 sel 5 ignored", pend_status, 0);
        bus_write(3'd7, 16'hBEEF);
        chk(pend_status == 16'h0 && wr_reject == 1'b0, "R6 sel 7 ignored", pend_status, 0);
        repeat (4) @(negedge clk_slow);
        for (int r = 0; r < NR; r++)
            chk(upd_cnt[r] == exp_cnt[r], "R6 R3 exactly once", upd_cnt[r], exp_cnt[r]);

        // R9 sticky set
        pulse_evt(4'hF);
        chk(irq_flags == 4'hF, "R9 flags set", irq_flags, 4'hF);

        // R7 zero-mask clear
        bus_clear(4'h0);
        chk(pend_status[8] == 1'b0, "R7 zero mask no pend", pend_status[8], 0);
        repeat (4) @(negedge clk_slow);
        chk(irq_flags == 4'hF && clr_cnt == 0, "R7 zero mask no effect", irq_flags, 4'hF);

        // R7 launch, R8 merge
        bus_clear(4'h1);
        chk(pend_status == 16'h0100, "R7 clear pending", pend_status, 16'h0100);
        bus_clear(4'h2);
        bus_clear(4'h4);
        chk(pend_status[8] == 1'b1, "R8 pending while merging", pend_status[8], 1);
        wait_idle("R8 idle");
        chk(irq_flags == 4'h8, "R8 no clear lost", irq_flags, 4'h8);
        chk(clr_cnt == 2, "R8 two transactions", clr_cnt, 2);
        chk(clr_union == 4'h7, "R8 union of masks", clr_union, 4'h7);

        // R9 zero bits leave flags alone
        pulse_evt(4'h3);
        chk(irq_flags == 4'hB, "R9 sticky add", irq_flags, 4'hB);
        bus_clear(4'h1);
        wait_idle("R9 idle");
        chk(irq_flags == 4'hA, "R9 partial clear", irq_flags, 4'hA);

        finish_run();
    end
endmodule